// File: doc/BRIEF.md
# SD SPI-Mode Command Engine

This block sends a single SD-card command in SPI mode and collects the card's answer. It sits in front of an 8-bit byte-exchange port, the SPI shifter, which is outside this block. For each byte it waits for the transmit side, hands over one byte, and takes back the byte that was clocked in at the same time. After a start strobe the engine builds the six-byte command frame from a 6-bit command index and a 32-bit argument. It sends one fill byte before the frame and one after it. It then polls for the card's status byte and reads the extra response bytes that the selected response kind needs.

Every command ends with a fixed release: fill bytes with the card still selected, then chip select raised, then more fill bytes. After that the block gives a one-cycle completion pulse. The status byte, the extra bytes and the timeout flag stay readable until the next accepted start. A controller issues the reset, wake-up, register-read and block-length commands one after another with this engine.

Top module: `sdspi_cmd_engine`

## Requirements
- R1: After reset, and whenever idle, `cs_n` is 1, `busy` is 0, `r1_status` is 0xFF, `resp_extra` is 0 and `timeout` is 0 until a start is accepted.
- R2: An accepted start gives exactly one cycle of `fifo_clr` while `cs_n` is 1. `cs_n` then goes to 0 before the first byte request.
- R3: The first eight bytes sent are 0xFF, then 0x40 OR `cmd_idx`, then `cmd_arg[31:24]`, `[23:16]`, `[15:8]`, `[7:0]`, then 0x95, then 0xFF.
- R4: `xfer_req` is raised only in a cycle where `tx_ready` is 1. After a request, no new request is made until `rx_valid` has returned that byte.
- R5: After the frame the engine sends 0xFF and takes the first received byte that is not 0xFF as `r1_status`. Bytes received during the frame are ignored.
- R6: If 18 polls in a row all return 0xFF, `timeout` is set, `r1_status` stays 0xFF, no extra bytes are read, and the release sequence still runs.
- R7: `resp_kind` selects the number of extra bytes, each read by sending 0xFF. 2'b00 reads none. 2'b01 reads one, placed in `resp_extra[7:0]`. 2'b10 reads four, the first of them in `resp_extra[31:24]`. 2'b11 behaves as 2'b00. Unused bytes read as 0.
- R8: Release: four 0xFF bytes are sent with `cs_n` at 0, then `cs_n` rises and two more 0xFF bytes are sent with `cs_n` at 1.
- R9: `done` is high for exactly one cycle, in the first cycle after the last release byte has been received. In that cycle `busy` is already 0.
- R10: `r1_status`, `resp_extra` and `timeout` hold their values while idle until the next accepted start.
- R11: A start raised while `busy` is 1 is ignored. The command in progress keeps its latched index and argument.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, accepted only when idle |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| resp_kind | input | 2 | Response kind: 00 short, 01 one extra byte, 10 four extra bytes, 11 as 00 |
| busy | output | 1 | High from an accepted start to completion |
| cs_n | output | 1 | Card chip select, active low |
| fifo_clr | output | 1 | Receive FIFO clear pulse |
| xfer_req | output | 1 | Byte exchange request |
| tx_byte | output | 8 | Byte to transmit, valid with `xfer_req` |
| tx_ready | input | 1 | Transmit side can accept a byte |
| rx_valid | input | 1 | Received byte is valid |
| rx_byte | input | 8 | Received byte |
| r1_status | output | 8 | Status byte from the card |
| resp_extra | output | 32 | Extra response bytes |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | No status byte within the poll limit |

## Verification
The hardest situation to reach from the ports is the poll window's edge. It needs a card that answers on exactly the 18th poll, and one that never answers, so that the counter is tested on both sides of its limit. The bench's card model takes a per-command reply latency. Directed runs set that latency to 17 and to 18, and random runs choose it across and beyond the window. The model also answers with non-0xFF bytes during the frame and varies the handshake delays, so that a status byte taken too early, or a request issued twice, shows up in the recorded byte stream.

// File: rtl/sdspi_pkg.sv
package sdspi_pkg;

  typedef enum logic [1:0] {
    RK_SHORT = 2'b00,
    RK_ONE   = 2'b01,
    RK_FOUR  = 2'b10,
    RK_RSV   = 2'b11
  } resp_kind_e;

  typedef enum logic [2:0] {
    EN_IDLE,
    EN_PREP,
    EN_FRAME,
    EN_POLL,
    EN_EXTRA,
    EN_HOLD,
    EN_TAIL
  } eng_state_e;

  localparam logic [7:0] FILL_BYTE = 8'hFF;

  // Byte at position pos of the padded command frame (8 positions).
  function automatic logic [7:0] frame_byte(input logic [2:0] pos,
                                            input logic [5:0] cmd,
                                            input logic [31:0] arg,
                                            input logic [7:0] crc);
    logic [7:0] b;
    case (pos)
      3'd1:    b = {2'b01, cmd};
      3'd2:    b = arg[31:24];
      3'd3:    b = arg[23:16];
      3'd4:    b = arg[15:8];
      3'd5:    b = arg[7:0];
      3'd6:    b = crc;
      default: b = FILL_BYTE;
    endcase
    return b;
  endfunction

  // Number of bytes that follow the status byte.
  function automatic logic [2:0] extra_len(input resp_kind_e k);
    logic [2:0] n;
    case (k)
      RK_ONE:  n = 3'd1;
      RK_FOUR: n = 3'd4;
      default: n = 3'd0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/sdspi_xchg.sv
module sdspi_xchg #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              xfer_req,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              idle,
  output logic              done,
  output logic [BYTE_W-1:0] rx_out
);
  typedef enum logic [1:0] {X_IDLE, X_TX, X_RX} x_state_e;
  x_state_e st;
  logic [BYTE_W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= X_IDLE;
      hold_q <= '1;
    end else begin
      case (st)
        X_IDLE: if (go) begin
          st     <= X_TX;
          hold_q <= byte_in;
        end
        X_TX:   if (tx_ready) st <= X_RX;
        X_RX:   if (rx_valid) st <= X_IDLE;
        default: st <= X_IDLE;
      endcase
    end
  end

  assign xfer_req = (st == X_TX) && tx_ready;
  assign tx_byte  = hold_q;
  assign idle     = (st == X_IDLE);
  assign done     = (st == X_RX) && rx_valid;
  assign rx_out   = rx_byte;
endmodule

// File: rtl/sdspi_frame_gen.sv
module sdspi_frame_gen
  import sdspi_pkg::*;
#(
  parameter logic [7:0] CRC_BYTE = 8'h95
) (
  input  logic        in_frame,
  input  logic [2:0]  pos,
  input  logic [5:0]  cmd,
  input  logic [31:0] arg,
  output logic [7:0]  byte_out
);
  assign byte_out = in_frame ? frame_byte(pos, cmd, arg, CRC_BYTE) : FILL_BYTE;
endmodule

// File: rtl/sdspi_cmd_engine.sv
module sdspi_cmd_engine
  import sdspi_pkg::*;
#(
  parameter int         POLL_LIMIT = 18,
  parameter int         PRE_REL    = 4,
  parameter int         POST_REL   = 2,
  parameter logic [7:0] CRC_BYTE   = 8'h95
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [5:0]  cmd_idx,
  input  logic [31:0] cmd_arg,
  input  logic [1:0]  resp_kind,
  output logic        busy,
  output logic        cs_n,
  output logic        fifo_clr,
  output logic        xfer_req,
  output logic [7:0]  tx_byte,
  input  logic        tx_ready,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  output logic [7:0]  r1_status,
  output logic [31:0] resp_extra,
  output logic        done,
  output logic        timeout
);
  localparam int FRAME_LEN = 8;
  localparam int CNT_MAX   = (POLL_LIMIT > FRAME_LEN) ? POLL_LIMIT : FRAME_LEN;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] FRAME_END = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] POLL_END  = CNT_W'(POLL_LIMIT - 1);
  localparam logic [CNT_W-1:0] PRE_END   = CNT_W'(PRE_REL - 1);
  localparam logic [CNT_W-1:0] POST_END  = CNT_W'(POST_REL - 1);

  eng_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [5:0]       cmd_q;
  logic [31:0]      arg_q;
  logic [2:0]       nextra_q;

  // Named internal events, also used by the bound checker.
  logic       start_accept;
  logic       byte_done;
  logic       poll_fire;
  logic       x_go;
  logic       x_idle;
  logic [7:0] x_rx;
  logic [7:0] next_byte;

  assign start_accept = start && (state == EN_IDLE);
  assign poll_fire    = byte_done && (state == EN_POLL);
  assign x_go = x_idle && (state inside {EN_FRAME, EN_POLL, EN_EXTRA, EN_HOLD, EN_TAIL});

  assign busy     = (state != EN_IDLE);
  assign fifo_clr = (state == EN_PREP);
  assign cs_n     = (state == EN_IDLE) || (state == EN_PREP) || (state == EN_TAIL);

  sdspi_frame_gen #(.CRC_BYTE(CRC_BYTE)) u_frame (
    .in_frame (state == EN_FRAME),
    .pos      (cnt[2:0]),
    .cmd      (cmd_q),
    .arg      (arg_q),
    .byte_out (next_byte)
  );

  sdspi_xchg #(.BYTE_W(8)) u_xchg (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (x_go),
    .byte_in  (next_byte),
    .tx_ready (tx_ready),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .xfer_req (xfer_req),
    .tx_byte  (tx_byte),
    .idle     (x_idle),
    .done     (byte_done),
    .rx_out   (x_rx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= EN_IDLE;
      cnt        <= '0;
      cmd_q      <= '0;
      arg_q      <= '0;
      nextra_q   <= '0;
      r1_status  <= FILL_BYTE;
      resp_extra <= '0;
      timeout    <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        EN_IDLE: if (start_accept) begin
          cmd_q      <= cmd_idx;
          arg_q      <= cmd_arg;
          nextra_q   <= extra_len(resp_kind_e'(resp_kind));
          r1_status  <= FILL_BYTE;
          resp_extra <= '0;
          timeout    <= 1'b0;
          cnt        <= '0;
          state      <= EN_PREP;
        end
        EN_PREP: state <= EN_FRAME;
        EN_FRAME: if (byte_done) begin
          if (cnt == FRAME_END) begin
            cnt   <= '0;
            state <= EN_POLL;
          end else cnt <= cnt + 1'b1;
        end
        EN_POLL: if (byte_done) begin
          if (x_rx != FILL_BYTE) begin
            r1_status <= x_rx;
            cnt       <= '0;
            state     <= (nextra_q == 3'd0) ? EN_HOLD : EN_EXTRA;
          end else if (cnt == POLL_END) begin
            timeout <= 1'b1;
            cnt     <= '0;
            state   <= EN_HOLD;
          end else cnt <= cnt + 1'b1;
        end
        EN_EXTRA: if (byte_done) begin
          resp_extra <= {resp_extra[23:0], x_rx};
          if (cnt == CNT_W'(nextra_q - 3'd1)) begin
            cnt   <= '0;
            state <= EN_HOLD;
          end else cnt <= cnt + 1'b1;
        end
        EN_HOLD: if (byte_done) begin
          if (cnt == PRE_END) begin
            cnt   <= '0;
            state <= EN_TAIL;
          end else cnt <= cnt + 1'b1;
        end
        EN_TAIL: if (byte_done) begin
          if (cnt == POST_END) begin
            cnt   <= '0;
            done  <= 1'b1;
            state <= EN_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= EN_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdspi_cmd_engine_chk.sv
module sdspi_cmd_engine_chk #(
  parameter int POLL_LIMIT = 18
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        cs_n,
  input logic        fifo_clr,
  input logic        xfer_req,
  input logic        tx_ready,
  input logic        rx_valid,
  input logic [7:0]  r1_status,
  input logic [31:0] resp_extra,
  input logic        done,
  input logic        timeout,
  input logic        start_accept,
  input logic        poll_fire
);
  localparam int PC_W = $clog2(POLL_LIMIT + 2);

  logic            outstanding;
  logic [PC_W-1:0] polls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outstanding <= 1'b0;
      polls       <= '0;
    end else begin
      if (xfer_req)      outstanding <= 1'b1;
      else if (rx_valid) outstanding <= 1'b0;
      if (start_accept)   polls <= '0;
      else if (poll_fire) polls <= polls + 1'b1;
    end
  end

  p_idle_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);
  p_clr_cs_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |-> cs_n);
  p_cs_fall_after_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(fifo_clr));
  p_req_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> tx_ready);
  p_one_outstanding_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> !outstanding);
  p_poll_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    polls <= PC_W'(POLL_LIMIT));
  p_timeout_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (r1_status == 8'hFF) && (resp_extra == 32'd0));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && cs_n);
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(r1_status) && $stable(resp_extra) && $stable(timeout)));
endmodule

bind sdspi_cmd_engine sdspi_cmd_engine_chk #(.POLL_LIMIT(POLL_LIMIT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .busy         (busy),
  .cs_n         (cs_n),
  .fifo_clr     (fifo_clr),
  .xfer_req     (xfer_req),
  .tx_ready     (tx_ready),
  .rx_valid     (rx_valid),
  .r1_status    (r1_status),
  .resp_extra   (resp_extra),
  .done         (done),
  .timeout      (timeout),
  .start_accept (start_accept),
  .poll_fire    (poll_fire)
);

// File: tb/sdspi_cmd_engine_tb.sv
module sdspi_cmd_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  cmd_idx = '0;
  logic [31:0] cmd_arg = '0;
  logic [1:0]  resp_kind = '0;
  logic        busy, cs_n, fifo_clr, xfer_req, done, timeout;
  logic [7:0]  tx_byte, r1_status;
  logic [31:0] resp_extra;
  logic        tx_ready = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = 8'h00;

  always #2 clk = ~clk;

  sdspi_cmd_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
    .resp_kind(resp_kind), .busy(busy), .cs_n(cs_n), .fifo_clr(fifo_clr),
    .xfer_req(xfer_req), .tx_byte(tx_byte), .tx_ready(tx_ready), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .r1_status(r1_status), .resp_extra(resp_extra), .done(done),
    .timeout(timeout)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // Card model state, set per command.
  int         xidx;
  int         lat;
  logic [7:0] r1v;
  logic [7:0] ext [4];
  logic [7:0] sent [64];
  logic       csr [64];
  bit         clr_seen;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int n_extra(input logic [1:0] k);
    if (k == 2'b01) return 1;
    if (k == 2'b10) return 4;
    return 0;
  endfunction

  function automatic logic [7:0] exp_frame(input int i, input logic [5:0] c, input logic [31:0] a);
    logic [63:0] f;
    f = {8'hFF, 2'b01, c, a, 8'h95, 8'hFF};
    return f[63 - 8*i -: 8];
  endfunction

  function automatic logic [7:0] card_reply(input int i);
    int k;
    if (i < 8) return 8'h5A ^ 8'(i);   // non-fill junk during the frame
    k = i - 8;
    if (k < lat) return 8'hFF;
    if (k == lat) return r1v;
    if (k <= lat + 4) return ext[k - lat - 1];
    return 8'hFF;
  endfunction

  // Card/shifter responder.
  initial begin : responder
    bit pend = 0;
    int dly = 0;
    logic [7:0] reply = 8'hFF;
    forever begin
      @(negedge clk);
      rx_valid = 1'b0;
      if (pend) begin
        if (dly == 0) begin
          rx_valid = 1'b1;
          rx_byte  = reply;
          pend     = 0;
        end else dly--;
      end
      tx_ready = ($urandom % 4) != 0;
      #1;
      if (fifo_clr && cs_n) clr_seen = 1;
      if (xfer_req) begin
        if (xidx < 64) begin
          sent[xidx] = tx_byte;
          csr[xidx]  = cs_n;
        end
        reply = card_reply(xidx);
        xidx++;
        pend = 1;
        dly  = $urandom % 3;
      end
    end
  end

  task automatic run_cmd(input logic [5:0] c, input logic [31:0] a, input logic [1:0] k,
                         input int l, input bit inject);
    int cyc;
    int npoll, nex, total, bad, first_bad;
    bit tmo, got;
    logic [31:0] er;
    logic [7:0] h_r1;
    logic [31:0] h_rx;
    logic h_to;
    lat = l;
    r1v = 8'($urandom) & 8'h7F;
    for (int j = 0; j < 4; j++) ext[j] = 8'($urandom);
    xidx = 0;
    clr_seen = 0;
    @(negedge clk);
    cmd_idx = c; cmd_arg = a; resp_kind = k; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cmd_idx = ~c; cmd_arg = ~a;
    got = 0;
    for (cyc = 0; cyc < 3000 && !got; cyc++) begin
      @(negedge clk);
      if (inject && cyc == 20) start = 1'b1;
      else start = 1'b0;
      #2;
      if (done) got = 1;
    end
    start = 1'b0;
    check(got, "R9 done seen (watchdog)", 32'(got), 32'd1);
    if (!got) return;
    check(!busy && cs_n, "R9 idle with done", {busy, cs_n}, 32'b01);
    tmo   = (l >= 18);
    npoll = tmo ? 18 : l + 1;
    nex   = tmo ? 0 : n_extra(k);
    total = 8 + npoll + nex + 6;
    check(xidx == total, "R5/R6/R7/R8 exchange count", 32'(xidx), 32'(total));
    check(clr_seen, "R2 fifo clear with cs high", 32'(clr_seen), 32'd1);
    bad = 0; first_bad = -1;
    for (int i = 0; i < 8; i++)
      if (sent[i] !== exp_frame(i, c, a)) begin bad++; if (first_bad < 0) first_bad = i; end
    check(bad == 0, inject ? "R11 frame unchanged by busy start" : "R3 frame bytes",
          first_bad < 0 ? 32'h0 : 32'(sent[first_bad]),
          first_bad < 0 ? 32'h0 : 32'(exp_frame(first_bad, c, a)));
    bad = 0;
    for (int i = 8; i < total && i < 64; i++) if (sent[i] !== 8'hFF) bad++;
    check(bad == 0, "R5 fill bytes after frame", 32'(bad), 32'd0);
    bad = 0;
    for (int i = 0; i < total && i < 64; i++)
      if (csr[i] !== (i >= total - 2)) bad++;
    check(bad == 0, "R8 chip select per byte", 32'(bad), 32'd0);
    check(timeout == tmo, "R6 timeout flag", 32'(timeout), 32'(tmo));
    check(r1_status == (tmo ? 8'hFF : r1v), "R5 status byte", 32'(r1_status), 32'(tmo ? 8'hFF : r1v));
    er = 32'd0;
    for (int j = 0; j < nex; j++) er = (er << 8) | 32'(ext[j]);
    check(resp_extra == er, "R7 extra bytes", resp_extra, er);
    @(negedge clk); #2;
    check(!done, "R9 done single cycle", 32'(done), 32'd0);
    h_r1 = r1_status; h_rx = resp_extra; h_to = timeout;
    repeat (5) @(negedge clk);
    #2;
    check(r1_status == h_r1 && resp_extra == h_rx && timeout == h_to,
          "R10 outputs hold while idle", {r1_status, 23'd0, timeout}, {h_r1, 23'd0, h_to});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #2;
    check(cs_n && !busy && !done && !xfer_req && !fifo_clr, "R1 reset state ctrl",
          {cs_n, busy, done, xfer_req, fifo_clr}, 32'b10000);
    check(r1_status == 8'hFF && resp_extra == 32'd0 && !timeout, "R1 reset state data",
          32'(r1_status), 32'hFF);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #2;
    check(cs_n && !busy, "R1 idle after reset", {cs_n, busy}, 32'b10);
    run_cmd(6'd0,  32'h0000_0000, 2'b00, 0,  0);
    run_cmd(6'd13, 32'h1234_5678, 2'b01, 3,  0);
    run_cmd(6'd58, 32'hA5C3_0F81, 2'b10, 17, 0);
    run_cmd(6'd55, 32'hDEAD_BEEF, 2'b10, 18, 0);
    run_cmd(6'd41, 32'h4000_0000, 2'b11, 2,  0);
    run_cmd(6'd16, 32'h0000_0200, 2'b10, 1,  1);
    for (int t = 0; t < 24; t++)
      run_cmd(6'($urandom), $urandom, 2'($urandom), int'($urandom % 22), 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule